// File: doc/BRIEF.md
# Prescaled Down-Counting Timer

This block is a general-purpose interval and event timer. An 8-bit down counter is advanced by the output of a 7-bit binary prescaler. The prescaler's input is chosen by a control register from four sources: the instruction-cycle enable, that enable gated by the external timer pin (for measuring pulse width), nothing at all, or falling edges of the external pin (for counting events). Software preloads the counter through a register write. It can read the counter at any time without disturbing it.

When a decrement brings the counter to zero, a request flag is set. The counter then keeps decrementing and wraps, so the value read later shows how many prescaled ticks have passed since the request. The interrupt output is the request flag qualified by a local mask bit. The processor's global interrupt mask is applied outside this block.

Top module: `prescaled_timer`

## Requirements
- R1: After reset the control register reads 0x77 (request flag 0, mask 1, source 11, prescaler-clear bit 0, tap select 111), the counter reads 0xFF and `irq` is 0.
- R2: A counter write (`reg_sel`=0) makes the counter read the written value in the next cycle. It overrides a decrement due in the same cycle.
- R3: With source 00 (control bits [5:4]), every cycle with `cyc_en`=1 is one prescaler input tick.
- R4: The tap select (control bits [2:0]) code k gives one counter decrement for every 2^k prescaler input ticks, counted from a cleared prescaler.
- R5: With source 01, a tick is a cycle with `cyc_en`=1 while the synchronized pin is high. The pin passes through two synchronizer flops before it takes effect.
- R6: With source 10, no stimulus on `cyc_en` or the pin changes the counter.
- R7: With source 11, each falling edge of the synchronized pin is one tick, and `cyc_en` is ignored.
- R8: A control write with bit 3 equal to 1 clears the prescaler and discards that cycle's tick. Bit 3 always reads 0.
- R9: A decrement from 1 to 0 sets the request flag (bit 7). The counter continues from 0 to 0xFF on the next decrement, and the flag stays set.
- R10: `irq` is 1 exactly when the request flag is 1 and the mask (bit 6) is 0.
- R11: A control write loads the request flag from wdata bit 7, so a 0 clears a pending request. A zero-reach in the same cycle wins and leaves the flag set.
- R12: Reading either register leaves the counter and the control register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_en | input | 1 | Instruction-cycle clock enable |
| tmr_pin | input | 1 | External timer pin, asynchronous |
| reg_sel | input | 1 | Register select: 0 counter, 1 control |
| wr_en | input | 1 | Write strobe for the selected register |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Read data of the selected register |
| irq | output | 1 | Masked interrupt request |

## Verification
A prescaler holding a stale count shows up as a counter decrement that comes one or more ticks early or late. This becomes visible at `rdata` only after up to 2^k input ticks, so the random runs span many taps and lengths and compare the final count with a closed-form expectation. A wrong source selection or synchronizer depth shows within a few cycles as extra or missing decrements in the gated and edge modes. A mishandled flag shows as a wrong bit 7 or `irq` in the cycle after the counter reaches zero, or after a control write.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
   typedef enum logic [1:0] {
      SRC_CYCLE = 2'b00,
      SRC_GATED = 2'b01,
      SRC_OFF   = 2'b10,
      SRC_PIN   = 2'b11
   } src_e;

   localparam int unsigned CTL_W     = 8;
   localparam int unsigned SEL_W     = 3;
   localparam int unsigned BIT_FLAG  = 7;
   localparam int unsigned BIT_MASK  = 6;
   localparam int unsigned BIT_SRCHI = 5;
   localparam int unsigned BIT_SRCLO = 4;
   localparam int unsigned BIT_PSCLR = 3;
endpackage

// File: rtl/ptmr_pin_sync.sv
module ptmr_pin_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic level_o,
   output logic fall_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("ptmr_pin_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sync_q;
   logic              prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], pin_i};
         prev_q <= sync_q[STAGES-1];
      end
   end

   assign level_o = sync_q[STAGES-1];
   assign fall_o  = prev_q & ~sync_q[STAGES-1];

   // R7: one falling edge never yields two back-to-back count enables
   assert_single_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fall_o |=> !fall_o);
endmodule

// File: rtl/ptmr_prescaler.sv
module ptmr_prescaler #(
   parameter int unsigned PS_W  = 7,
   parameter int unsigned SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             clr_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic             tap_o
);
   generate
      if (PS_W < 1 || PS_W >= (1 << SEL_W)) begin : g_bad_width
         $error("ptmr_prescaler: PS_W out of range for SEL_W");
      end
   endgenerate

   localparam logic [SEL_W-1:0] SEL_MAX = SEL_W'(PS_W);

   logic [PS_W-1:0] ps_q;
   logic [PS_W:0]   roll_vec;
   logic [SEL_W-1:0] eff_sel;

   generate
      for (genvar k = 0; k <= PS_W; k++) begin : g_tap
         if (k == 0) begin : g_div1
            assign roll_vec[k] = 1'b1;
         end else begin : g_divn
            assign roll_vec[k] = &ps_q[k-1:0];
         end
      end
   endgenerate

   assign eff_sel = (sel_i > SEL_MAX) ? SEL_MAX : sel_i;
   assign tap_o   = tick_i & ~clr_i & roll_vec[eff_sel];

   always_ff @(posedge clk) begin
      if (!rst_n)      ps_q <= '0;
      else if (clr_i)  ps_q <= '0;
      else if (tick_i) ps_q <= ps_q + 1'b1;
   end

   assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (ps_q == '0));
   assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !clr_i) |=> $stable(ps_q));
   assert_tap_needs_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
      tap_o |-> tick_i);
endmodule

// File: rtl/ptmr_downcounter.sv
module ptmr_downcounter #(
   parameter int unsigned W = 8,
   parameter logic [W-1:0] RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] load_val_i,
   input  logic         dec_i,
   input  logic         flag_wr_i,
   input  logic         flag_val_i,
   output logic [W-1:0] cnt_o,
   output logic         flag_o
);
   logic [W-1:0] cnt_q;
   logic         flag_q;
   logic         hit;

   assign hit = dec_i & ~load_i & (cnt_q == W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= RST_VAL;
         flag_q <= 1'b0;
      end else begin
         if (load_i)     cnt_q <= load_val_i;
         else if (dec_i) cnt_q <= cnt_q - 1'b1;
         if (hit)            flag_q <= 1'b1;
         else if (flag_wr_i) flag_q <= flag_val_i;
      end
   end

   assign cnt_o  = cnt_q;
   assign flag_o = flag_q;

   assert_load_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (cnt_q == $past(load_val_i)));
   assert_no_drift_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !dec_i) |=> $stable(cnt_q));
   assert_flag_on_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(flag_q) && !$past(flag_wr_i)) |-> (cnt_q == '0));
   assert_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_i && !load_i && cnt_q == '0) |=> (cnt_q == '1));
endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer #(
   parameter int unsigned CNT_W       = 8,
   parameter int unsigned PS_W        = 7,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cyc_en,
   input  logic             tmr_pin,
   input  logic             reg_sel,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wdata,
   output logic [CNT_W-1:0] rdata,
   output logic             irq
);
   import ptmr_pkg::*;

   generate
      if (CNT_W < CTL_W) begin : g_bad_cnt
         $error("prescaled_timer: CNT_W must hold the control register");
      end
   endgenerate

   logic             mask_q;
   src_e             src_q;
   logic [SEL_W-1:0] div_q;

   logic             ctl_wr, cnt_wr, ps_clr;
   logic             pin_lvl, pin_fall;
   logic             src_tick, tap;
   logic [CNT_W-1:0] cnt;
   logic             flag;
   logic [CTL_W-1:0] ctl_rd;

   assign ctl_wr = wr_en &  reg_sel;
   assign cnt_wr = wr_en & ~reg_sel;
   assign ps_clr = ctl_wr & wdata[BIT_PSCLR];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q <= 1'b1;
         src_q  <= SRC_PIN;
         div_q  <= '1;
      end else if (ctl_wr) begin
         mask_q <= wdata[BIT_MASK];
         src_q  <= src_e'(wdata[BIT_SRCHI:BIT_SRCLO]);
         div_q  <= wdata[SEL_W-1:0];
      end
   end

   ptmr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin_i(tmr_pin),
      .level_o(pin_lvl), .fall_o(pin_fall)
   );

   always_comb begin
      case (src_q)
         SRC_CYCLE: src_tick = cyc_en;
         SRC_GATED: src_tick = cyc_en & pin_lvl;
         SRC_PIN:   src_tick = pin_fall;
         default:   src_tick = 1'b0;
      endcase
   end

   ptmr_prescaler #(.PS_W(PS_W), .SEL_W(SEL_W)) u_ps (
      .clk(clk), .rst_n(rst_n), .tick_i(src_tick), .clr_i(ps_clr),
      .sel_i(div_q), .tap_o(tap)
   );

   ptmr_downcounter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load_i(cnt_wr), .load_val_i(wdata),
      .dec_i(tap), .flag_wr_i(ctl_wr), .flag_val_i(wdata[BIT_FLAG]),
      .cnt_o(cnt), .flag_o(flag)
   );

   assign ctl_rd = {flag, mask_q, src_q, 1'b0, div_q};
   assign rdata  = reg_sel ? CNT_W'(ctl_rd) : cnt;
   assign irq    = flag & ~mask_q;

   assert_off_no_tap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (src_q == SRC_OFF) |-> !tap);
   assert_mask_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && wdata[BIT_MASK]) |=> !irq);
   assert_pin_ignores_cyc_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (src_q == SRC_PIN && !pin_fall) |-> !tap);
endmodule

// File: tb/prescaled_timer_test.sv
module prescaled_timer_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cyc_en = 1'b0;
   logic       tmr_pin = 1'b0;
   logic       reg_sel = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       irq;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #4 clk = ~clk;

   prescaled_timer uut (
      .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .tmr_pin(tmr_pin),
      .reg_sel(reg_sel), .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .irq(irq)
   );

   function automatic logic [7:0] mk(input bit f, input bit m, input int src,
                                     input bit clr, input int dv);
      return {f, m, src[1:0], clr, dv[2:0]};
   endfunction

   function automatic int exp_cnt(input int start, input int ticks, input int dv);
      return (start - (ticks >> dv)) & 255;
   endfunction

   function automatic bit exp_flag(input int start, input int ticks, input int dv);
      int first;
      first = (start == 0) ? 256 : start;
      return (ticks >> dv) >= first;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input bit sel, input logic [7:0] d);
      reg_sel = sel; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input bit sel, output int v);
      reg_sel = sel;
      #1;
      v = rdata;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int v;
      void'($urandom(32'h5eed_1234));
      idle(3);
      rst_n = 1'b1;
      // R1 reset state
      rd(1, v); chk("R1 control", v, 8'h77);
      rd(0, v); chk("R1 counter", v, 8'hFF);
      chk("R1 irq", irq, 0);

      // R12 reads do not disturb (source 11, pin idle)
      for (int i = 0; i < 4; i++) begin
         rd(0, v); chk("R12 counter stable", v, 8'hFF);
         rd(1, v); chk("R12 control stable", v, 8'h77);
         @(negedge clk);
      end

      // R2 counter write wins over decrement
      wr(1, mk(0, 1, 0, 1, 0));
      cyc_en = 1'b1;
      wr(0, 8'h5A);
      cyc_en = 1'b0;
      rd(0, v); chk("R2 load priority", v, 8'h5A);

      // R3/R4 random runs in source 00
      for (int t = 0; t < 40; t++) begin
         int dv, start, n, ones;
         dv = $urandom % 8; start = $urandom % 256; n = 20 + $urandom % 300;
         ones = 0;
         cyc_en = 1'b0;
         wr(1, mk(0, 1, 0, 1, dv));
         wr(0, start[7:0]);
         for (int c = 0; c < n; c++) begin
            cyc_en = $urandom % 2;
            ones += cyc_en;
            @(negedge clk);
         end
         cyc_en = 1'b0;
         rd(0, v); chk("R3 R4 random count", v, exp_cnt(start, ones, dv));
         rd(1, v); chk("R9 random flag", v >> 7, exp_flag(start, ones, dv));
      end

      // R5 gated source
      wr(1, mk(0, 1, 1, 1, 0));
      wr(0, 8'd100);
      tmr_pin = 1'b1; idle(3);
      cyc_en = 1'b1; idle(10); cyc_en = 1'b0;
      rd(0, v); chk("R5 gated pin high", v, 90);
      tmr_pin = 1'b0; idle(3);
      cyc_en = 1'b1; idle(10); cyc_en = 1'b0;
      rd(0, v); chk("R5 gated pin low", v, 90);

      // R6 source disabled
      wr(1, mk(0, 1, 2, 1, 0));
      wr(0, 8'd77);
      cyc_en = 1'b1;
      for (int i = 0; i < 5; i++) begin
         tmr_pin = 1'b1; idle(3); tmr_pin = 1'b0; idle(3);
      end
      cyc_en = 1'b0;
      rd(0, v); chk("R6 disabled", v, 77);

      // R7 pin edges, cyc_en ignored
      wr(1, mk(0, 1, 3, 1, 0));
      wr(0, 8'd50);
      cyc_en = 1'b1;
      for (int i = 0; i < 6; i++) begin
         tmr_pin = 1'b1; idle(4); tmr_pin = 1'b0; idle(4);
      end
      cyc_en = 1'b0;
      rd(0, v); chk("R7 pin edges div1", v, 44);
      wr(1, mk(0, 1, 3, 1, 1));
      wr(0, 8'd50);
      for (int i = 0; i < 6; i++) begin
         tmr_pin = 1'b1; idle(4); tmr_pin = 1'b0; idle(4);
      end
      rd(0, v); chk("R7 pin edges div2", v, 47);

      // R8 prescaler clear
      wr(1, mk(0, 1, 0, 1, 2));
      wr(0, 8'd30);
      cyc_en = 1'b1; idle(3); cyc_en = 1'b0;
      rd(0, v); chk("R8 before clear", v, 30);
      rd(1, v); chk("R8 bit3 reads zero", v, mk(0, 1, 0, 0, 2));
      wr(1, mk(0, 1, 0, 1, 2));
      cyc_en = 1'b1; idle(1); cyc_en = 1'b0;
      rd(0, v); chk("R8 cleared prescaler", v, 30);
      cyc_en = 1'b1; idle(3); cyc_en = 1'b0;
      rd(0, v); chk("R8 full period", v, 29);

      // R9 zero reach and wrap
      wr(1, mk(0, 1, 0, 1, 0));
      wr(0, 8'd2);
      cyc_en = 1'b1; idle(2); cyc_en = 1'b0;
      rd(0, v); chk("R9 at zero", v, 0);
      rd(1, v); chk("R9 flag set", v >> 7, 1);
      chk("R10 masked irq", irq, 0);
      cyc_en = 1'b1; idle(1); cyc_en = 1'b0;
      rd(0, v); chk("R9 wrap", v, 8'hFF);
      rd(1, v); chk("R9 flag held", v >> 7, 1);

      // R10 / R11 mask and flag writes
      wr(1, mk(1, 0, 0, 0, 0));
      #1; chk("R10 irq unmasked", irq, 1);
      wr(1, mk(1, 1, 0, 0, 0));
      #1; chk("R10 irq masked", irq, 0);
      wr(1, mk(1, 0, 0, 0, 0));
      #1; chk("R10 irq again", irq, 1);
      wr(1, mk(0, 0, 0, 0, 0));
      #1; chk("R11 flag cleared irq", irq, 0);
      rd(1, v); chk("R11 flag cleared", v >> 7, 0);

      // R11 zero reach beats clearing write
      wr(1, mk(0, 1, 0, 0, 0));
      wr(0, 8'd1);
      cyc_en = 1'b1;
      wr(1, mk(0, 1, 0, 0, 0));
      cyc_en = 1'b0;
      rd(0, v); chk("R11 counter zero", v, 0);
      rd(1, v); chk("R11 hit wins", v >> 7, 1);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule